// File: doc/BRIEF.md
# Serial Channel Interrupt Prioritizer

This block gathers every interrupt cause of one serial channel, masks them with an 8-bit enable register and presents two things to the host. The first is a 6-bit status code that names the single most urgent enabled cause. The second is one interrupt line that stays high while any enabled cause is pending. The causes are: line errors, receive FIFO level, receive idle timeout, transmit readiness, modem line changes, flow-control character detection, and rising edges on the handshake inputs and outputs. The FIFOs, the bit-rate generator, the serializer and the host bus are outside the block. They reach it only as plain level, pulse and strobe inputs.

Each cause has its own rule for going away. Reading the line status register, reading the modem status register, reading the interrupt status register, draining the receive FIFO, or the source level falling each remove a different set of causes. A status read removes only the cause it reported. Everything below that cause stays pending and shows up on later reads. The receive idle timeout is measured in bit-rate ticks. It lasts four character times plus twelve bit times, with the character length set by a parameter.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The enable register is 0 after reset and loads `ien_wdata` (with bit 4 forced to 0) on a cycle with `ien_we` high. Bit 0 enables receive data and receive timeout, bit 1 transmit ready, bit 2 line status, bit 3 modem status, bit 5 flow character, bit 6 output change and bit 7 input change. Causes latch even while masked. With no enabled cause pending, `isr_code` is 0x01 and `irq` is low.
- R2: Enable bits 5, 6 and 7 count only while `efr_enh` is 1.
- R3: A 0-to-1 change on any bit of `lsr_err` latches the line status cause. A cycle with `rd_lsr` high clears it, even though `lsr_err` stays high.
- R4: The receive data cause is present exactly while `rx_fill` >= `rx_trig`, where `rx_trig` is at least 1.
- R5: While `rx_fill` is non-zero, a counter advances on `bit_tick`. It restarts on `rx_char` or `rx_rd`. Once it has counted 4*CHAR_BITS+12 ticks, the timeout cause is set on the next edge. The timeout cause is removed only when `rx_fill` is 0.
- R6: The transmit level is `tx_trig_hit` when `fifo_mode` is 1 and `lsr_thre` otherwise. A rise of that level latches the transmit cause. The cause is cleared by an `rd_isr` cycle that reports code 0x02, or when the level falls.
- R7: A 0-to-1 change on any bit of `msr_delta` latches the modem cause. An `rd_msr` cycle clears it.
- R8: A 0-to-1 change on `flow_det` latches the flow character cause. An `rd_isr` cycle that reports code 0x10 clears it.
- R9: With `auto_cts_en` high, a rise of the selected input latches the input-change cause. The selected input is `cts_in` when `mcr_sel`=0 and `dsr_in` when `mcr_sel`=1. With `auto_rts_en` high, a rise of `rts_out` or `dtr_out`, chosen the same way, latches the output-change cause. An `rd_msr` cycle clears both causes.
- R10: Codes in falling priority are 0x06 line status, 0x0C timeout, 0x04 receive data, 0x02 transmit, 0x00 modem, 0x10 flow character and 0x20 pin change. An `rd_isr` cycle clears nothing except the reported transmit or flow cause.
- R11: `irq` is high exactly when `isr_code` is not 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ien_we | input | 1 | Enable register write strobe |
| ien_wdata | input | 8 | Enable register write data |
| efr_enh | input | 1 | Enhanced features on |
| fifo_mode | input | 1 | Transmit level from FIFO trigger |
| mcr_sel | input | 1 | 0 picks CTS/RTS pair, 1 picks DSR/DTR pair |
| auto_cts_en | input | 1 | Automatic input flow control on |
| auto_rts_en | input | 1 | Automatic output flow control on |
| lsr_err | input | 4 | Line error status bits |
| lsr_thre | input | 1 | Transmit holding register empty |
| tx_trig_hit | input | 1 | Transmit FIFO at trigger level |
| rx_fill | input | FILL_W | Receive FIFO fill count |
| rx_trig | input | FILL_W | Receive trigger level |
| rx_char | input | 1 | Character written into receive FIFO |
| rx_rd | input | 1 | Receive FIFO read |
| bit_tick | input | 1 | One pulse per bit time |
| msr_delta | input | 4 | Modem change status bits |
| flow_det | input | 1 | Xon/Xoff/special character detected |
| cts_in | input | 1 | CTS input level |
| dsr_in | input | 1 | DSR input level |
| rts_out | input | 1 | RTS output level |
| dtr_out | input | 1 | DTR output level |
| rd_isr | input | 1 | Interrupt status register read |
| rd_lsr | input | 1 | Line status register read |
| rd_msr | input | 1 | Modem status register read |
| isr_code | output | 6 | Highest enabled pending code |
| irq | output | 1 | Interrupt request |

## Verification
The bench holds `lsr_err` high through a line status read. A design that treats the cause as a level would keep reporting 0x06. It issues status reads while several causes are pending. A design that cleared on any status read, rather than only the reported source, would lose the transmit or modem cause early. The timeout window is cut short by a FIFO read and then run past its limit. An off-by-one counter, or one that restarts on the wrong events, would report 0x0C on the wrong cycle, or would drop it before the FIFO empties. The bench also changes `mcr_sel` and the enhanced-features bit. This exposes wrong pin selection and enable gating that ignores `efr_enh`.

// File: rtl/uart_irq_pkg.sv
// Package: status codes of the interrupt prioritizer and the mapping from
// priority rank (0 = most urgent) to the code reported for that rank.
package uart_irq_pkg;

    localparam int NSRC = 7;

    typedef enum logic [5:0] {
        CODE_MODEM  = 6'h00,
        CODE_NONE   = 6'h01,
        CODE_TXRDY  = 6'h02,
        CODE_RXDATA = 6'h04,
        CODE_LINE   = 6'h06,
        CODE_RXTO   = 6'h0C,
        CODE_FLOW   = 6'h10,
        CODE_PINCHG = 6'h20
    } irq_code_e;

    // Code reported for a given priority rank.
    function automatic irq_code_e code_of_rank(input int unsigned rank);
        case (rank)
            0:       return CODE_LINE;
            1:       return CODE_RXTO;
            2:       return CODE_RXDATA;
            3:       return CODE_TXRDY;
            4:       return CODE_MODEM;
            5:       return CODE_FLOW;
            default: return CODE_PINCHG;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_latch.sv
// Module: pending-flag latch for one interrupt cause.
// Sets on a 0-to-1 change of any bit of sig while arm is high. Clears on clr,
// and a set in the same cycle wins over the clear. With HOLD_LEVEL=1 the flag
// also drops as soon as all bits of sig are low.
// Assumes sig is synchronous to clk.
module uart_irq_latch #(
    parameter int W          = 1,
    parameter bit HOLD_LEVEL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig,
    input  logic         arm,
    input  logic         clr,
    output logic         pend
);

    logic [W-1:0] prev_q;
    logic         pend_q;
    logic         pend_d;
    logic         rise;

    assign rise = arm && ((sig & ~prev_q) != '0);

    generate
        if (HOLD_LEVEL) begin : g_hold
            // Next flag: set or keep, but only while the level is present.
            always_comb pend_d = (|sig) && (rise || (pend_q && !clr));
        end else begin : g_sticky
            // Next flag: set or keep until cleared.
            always_comb pend_d = rise || (pend_q && !clr);
        end
    endgenerate

    // Register the previous input and the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= sig;
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/uart_irq_rx_timer.sv
// Module: receive idle timeout.
// Counts bit_tick while the receive FIFO is not empty and restarts on every
// received character or FIFO read. After LIMIT ticks the flag is set on the
// next edge. The flag holds until the FIFO is empty.
// Assumes bit_tick is a single-cycle pulse per bit time.
module uart_irq_rx_timer #(
    parameter int CHAR_BITS = 10,
    parameter int FILL_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] rx_fill,
    input  logic              rx_char,
    input  logic              rx_rd,
    input  logic              bit_tick,
    output logic              timed_out
);

    localparam int LIMIT = 4 * CHAR_BITS + 12;
    localparam int CW    = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;
    logic          to_q;
    logic          not_empty;

    assign not_empty = (rx_fill != '0);

    // Idle counter: restart on activity or empty, saturate at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!not_empty || rx_char || rx_rd) begin
            cnt_q <= '0;
        end else if (bit_tick && (cnt_q != CW'(LIMIT))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Timeout flag: set at LIMIT, held until the FIFO drains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_q <= 1'b0;
        end else begin
            to_q <= not_empty && (to_q || (cnt_q == CW'(LIMIT)));
        end
    end

    assign timed_out = to_q;

endmodule

// File: rtl/uart_irq_prio.sv
// Module: fixed-priority encoder. req[0] is the most urgent cause. The output
// is the code of the lowest-indexed set request, or CODE_NONE when none is set.
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NSRC-1:0] req,
    output irq_code_e       code
);

    // Walk from least to most urgent so that the most urgent one is kept.
    always_comb begin
        code = CODE_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) code = code_of_rank(i);
        end
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
// Module: interrupt prioritizer for one serial channel (top).
// Holds the enable register and one pending flag per cause. Each flag has its
// own clear rule. The block reports the most urgent enabled cause as a code
// and raises irq while any enabled cause is pending.
// Assumes all inputs are synchronous to clk and that rx_trig >= 1.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int CHAR_BITS = 10,
    parameter int FILL_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ien_we,
    input  logic [7:0]        ien_wdata,
    input  logic              efr_enh,
    input  logic              fifo_mode,
    input  logic              mcr_sel,
    input  logic              auto_cts_en,
    input  logic              auto_rts_en,
    input  logic [3:0]        lsr_err,
    input  logic              lsr_thre,
    input  logic              tx_trig_hit,
    input  logic [FILL_W-1:0] rx_fill,
    input  logic [FILL_W-1:0] rx_trig,
    input  logic              rx_char,
    input  logic              rx_rd,
    input  logic              bit_tick,
    input  logic [3:0]        msr_delta,
    input  logic              flow_det,
    input  logic              cts_in,
    input  logic              dsr_in,
    input  logic              rts_out,
    input  logic              dtr_out,
    input  logic              rd_isr,
    input  logic              rd_lsr,
    input  logic              rd_msr,
    output logic [5:0]        isr_code,
    output logic              irq
);

    localparam logic [7:0] IEN_MASK = 8'hEF;

    logic [7:0]      ien_q;
    logic            line_p, to_p, tx_p, modem_p, flow_p, inchg_p, outchg_p;
    logic            rx_lvl, tx_lvl, in_sel, out_sel;
    logic            tx_clr, flow_clr;
    logic [NSRC-1:0] req;
    irq_code_e       code;

    // Enable register with the reserved bit held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else if (ien_we) begin
            ien_q <= ien_wdata & IEN_MASK;
        end
    end

    assign rx_lvl   = (rx_fill >= rx_trig);
    assign tx_lvl   = fifo_mode ? tx_trig_hit : lsr_thre;
    assign in_sel   = mcr_sel ? dsr_in : cts_in;
    assign out_sel  = mcr_sel ? dtr_out : rts_out;
    assign tx_clr   = rd_isr && (code == CODE_TXRDY);
    assign flow_clr = rd_isr && (code == CODE_FLOW);

    uart_irq_latch #(.W(4), .HOLD_LEVEL(1'b0)) u_line (
        .clk(clk), .rst_n(rst_n), .sig(lsr_err), .arm(1'b1),
        .clr(rd_lsr), .pend(line_p)
    );

    uart_irq_rx_timer #(.CHAR_BITS(CHAR_BITS), .FILL_W(FILL_W)) u_rxto (
        .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .rx_char(rx_char),
        .rx_rd(rx_rd), .bit_tick(bit_tick), .timed_out(to_p)
    );

    uart_irq_latch #(.W(1), .HOLD_LEVEL(1'b1)) u_tx (
        .clk(clk), .rst_n(rst_n), .sig(tx_lvl), .arm(1'b1),
        .clr(tx_clr), .pend(tx_p)
    );

    uart_irq_latch #(.W(4), .HOLD_LEVEL(1'b0)) u_modem (
        .clk(clk), .rst_n(rst_n), .sig(msr_delta), .arm(1'b1),
        .clr(rd_msr), .pend(modem_p)
    );

    uart_irq_latch #(.W(1), .HOLD_LEVEL(1'b0)) u_flow (
        .clk(clk), .rst_n(rst_n), .sig(flow_det), .arm(1'b1),
        .clr(flow_clr), .pend(flow_p)
    );

    uart_irq_latch #(.W(1), .HOLD_LEVEL(1'b0)) u_inchg (
        .clk(clk), .rst_n(rst_n), .sig(in_sel), .arm(auto_cts_en),
        .clr(rd_msr), .pend(inchg_p)
    );

    uart_irq_latch #(.W(1), .HOLD_LEVEL(1'b0)) u_outchg (
        .clk(clk), .rst_n(rst_n), .sig(out_sel), .arm(auto_rts_en),
        .clr(rd_msr), .pend(outchg_p)
    );

    // Masked requests in priority rank order.
    always_comb begin
        req    = '0;
        req[0] = line_p  && ien_q[2];
        req[1] = to_p    && ien_q[0];
        req[2] = rx_lvl  && ien_q[0];
        req[3] = tx_p    && ien_q[1];
        req[4] = modem_p && ien_q[3];
        req[5] = flow_p  && ien_q[5] && efr_enh;
        req[6] = ((inchg_p && ien_q[7]) || (outchg_p && ien_q[6])) && efr_enh;
    end

    uart_irq_prio u_prio (
        .req(req),
        .code(code)
    );

    assign isr_code = code;
    assign irq      = |req;

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
// Module: assertion checker bound to uart_irq_ctrl. It observes ports and the
// enable register only.
module uart_irq_ctrl_chk #(
    parameter int FILL_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        ien_q,
    input logic              efr_enh,
    input logic [3:0]        lsr_err,
    input logic [3:0]        msr_delta,
    input logic [FILL_W-1:0] rx_fill,
    input logic [FILL_W-1:0] rx_trig,
    input logic              rd_lsr,
    input logic              rd_msr,
    input logic [5:0]        isr_code,
    input logic              irq
);

    assert_masked_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == 8'h00) |-> (!irq && isr_code == 6'h01));

    assert_enh_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!efr_enh && ien_q[3:0] == 4'h0) |-> !irq);

    assert_line_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rd_lsr && isr_code == 6'h06 &&
         ((lsr_err & ~$past(lsr_err)) == 4'h0)) |=> (isr_code != 6'h06));

    assert_rx_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q[0] && rx_fill >= rx_trig && isr_code != 6'h06 && isr_code != 6'h0C)
        |-> (isr_code == 6'h04));

    assert_to_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fill == '0) |=> (isr_code != 6'h0C));

    assert_modem_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rd_msr && ((msr_delta & ~$past(msr_delta)) == 4'h0))
        |=> (isr_code != 6'h00));

    assert_irq_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq != (isr_code == 6'h01));

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.FILL_W(FILL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ien_q(ien_q), .efr_enh(efr_enh),
    .lsr_err(lsr_err), .msr_delta(msr_delta), .rx_fill(rx_fill),
    .rx_trig(rx_trig), .rd_lsr(rd_lsr), .rd_msr(rd_msr),
    .isr_code(isr_code), .irq(irq)
);

// File: tb/uart_irq_ctrl_test.sv
// Bench: a behavioural reference model updated on every clock edge and
// compared with the outputs in every cycle of each scenario.
module uart_irq_ctrl_test;

    localparam int CB    = 10;
    localparam int FW    = 5;
    localparam int LIMIT = 4 * CB + 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ien_we = 0, efr_enh = 0, fifo_mode = 0, mcr_sel = 0;
    logic auto_cts_en = 0, auto_rts_en = 0, lsr_thre = 0, tx_trig_hit = 0;
    logic rx_char = 0, rx_rd = 0, bit_tick = 0, flow_det = 0;
    logic cts_in = 0, dsr_in = 0, rts_out = 0, dtr_out = 0;
    logic rd_isr = 0, rd_lsr = 0, rd_msr = 0;
    logic [7:0] ien_wdata = 0;
    logic [3:0] lsr_err = 0, msr_delta = 0;
    logic [FW-1:0] rx_fill = 0, rx_trig = 5'd4;
    logic [5:0] isr_code;
    logic irq;

    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_irq_ctrl #(.CHAR_BITS(CB), .FILL_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .ien_we(ien_we), .ien_wdata(ien_wdata),
        .efr_enh(efr_enh), .fifo_mode(fifo_mode), .mcr_sel(mcr_sel),
        .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en),
        .lsr_err(lsr_err), .lsr_thre(lsr_thre), .tx_trig_hit(tx_trig_hit),
        .rx_fill(rx_fill), .rx_trig(rx_trig), .rx_char(rx_char), .rx_rd(rx_rd),
        .bit_tick(bit_tick), .msr_delta(msr_delta), .flow_det(flow_det),
        .cts_in(cts_in), .dsr_in(dsr_in), .rts_out(rts_out), .dtr_out(dtr_out),
        .rd_isr(rd_isr), .rd_lsr(rd_lsr), .rd_msr(rd_msr),
        .isr_code(isr_code), .irq(irq)
    );

    // Reference model state
    logic [7:0] m_ien = 0;
    bit m_line, m_to, m_tx, m_modem, m_flow, m_in, m_out;
    logic [3:0] p_lsr = 0, p_msr = 0;
    bit p_tx, p_flow, p_in, p_out;
    int tcnt = 0;

    function automatic logic [5:0] m_code();
        int codes[7] = '{6, 12, 4, 2, 0, 16, 32};
        bit pend[7];
        pend[0] = m_line && m_ien[2];
        pend[1] = m_to && m_ien[0];
        pend[2] = (rx_fill >= rx_trig) && m_ien[0];
        pend[3] = m_tx && m_ien[1];
        pend[4] = m_modem && m_ien[3];
        pend[5] = m_flow && m_ien[5] && efr_enh;
        pend[6] = efr_enh && ((m_in && m_ien[7]) || (m_out && m_ien[6]));
        foreach (pend[i]) if (pend[i]) return 6'(codes[i]);
        return 6'h01;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ien = 0; m_line = 0; m_to = 0; m_tx = 0; m_modem = 0;
            m_flow = 0; m_in = 0; m_out = 0; p_lsr = 0; p_msr = 0;
            p_tx = 0; p_flow = 0; p_in = 0; p_out = 0; tcnt = 0;
        end else begin
            logic [5:0] c;
            bit txl, ins, outs, nto;
            c    = m_code();
            txl  = fifo_mode ? tx_trig_hit : lsr_thre;
            ins  = mcr_sel ? dsr_in : cts_in;
            outs = mcr_sel ? dtr_out : rts_out;
            m_line  = ((lsr_err & ~p_lsr) != 0) || (m_line && !rd_lsr);
            m_tx    = txl && ((txl && !p_tx) || (m_tx && !(rd_isr && c == 6'h02)));
            m_modem = ((msr_delta & ~p_msr) != 0) || (m_modem && !rd_msr);
            m_flow  = (flow_det && !p_flow) || (m_flow && !(rd_isr && c == 6'h10));
            m_in    = (auto_cts_en && ins && !p_in) || (m_in && !rd_msr);
            m_out   = (auto_rts_en && outs && !p_out) || (m_out && !rd_msr);
            nto = (rx_fill != 0) && (m_to || tcnt == LIMIT);
            if (rx_fill == 0 || rx_char || rx_rd) tcnt = 0;
            else if (bit_tick && tcnt < LIMIT) tcnt++;
            m_to = nto;
            if (ien_we) m_ien = ien_wdata & 8'hEF;
            p_lsr = lsr_err; p_msr = msr_delta; p_tx = txl;
            p_flow = flow_det; p_in = ins; p_out = outs;
        end
    end

    // Compare one cycle, then release single-cycle strobes.
    task automatic step(input string tag);
        logic [5:0] ec;
        #2;
        ec = m_code();
        checks++;
        if (isr_code !== ec || irq !== (ec != 6'h01)) begin
            errors++;
            $display("FAIL %s: code=%h irq=%b expected code=%h irq=%b",
                     tag, isr_code, irq, ec, (ec != 6'h01));
        end
        @(negedge clk);
        ien_we = 0; rd_isr = 0; rd_lsr = 0; rd_msr = 0;
        rx_char = 0; rx_rd = 0; flow_det = 0;
    endtask

    task automatic steps(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL all: watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        steps(2, "R1");                       // reset state
        rst_n = 1;
        // R1: masked causes keep irq low
        lsr_err = 4'b0010; steps(3, "R1");
        lsr_err = 0;
        ien_we = 1; ien_wdata = 8'hFF; steps(2, "R1");
        // R3: line status clears on read despite held bits
        rd_lsr = 1; steps(2, "R3");
        lsr_err = 4'b1000; steps(2, "R3");
        rd_lsr = 1; steps(3, "R3");
        lsr_err = 0;
        // R4: receive level
        rx_fill = 3; step("R4");
        rx_fill = 4; step("R4");
        rx_fill = 5; step("R4");
        rx_fill = 3; step("R4");
        // R5: idle timeout
        rx_fill = 1; rx_char = 1; step("R5");
        bit_tick = 1; steps(40, "R5");
        rx_rd = 1; steps(60, "R5");
        bit_tick = 0; steps(3, "R5");
        rx_fill = 0; steps(3, "R5");
        // R6: transmit ready, both modes
        lsr_thre = 1; steps(2, "R6");
        rd_isr = 1; steps(2, "R6");
        lsr_thre = 0; fifo_mode = 1; tx_trig_hit = 1; steps(2, "R6");
        tx_trig_hit = 0; steps(2, "R6");
        // R7: modem change
        msr_delta = 4'b0001; steps(2, "R7");
        rd_msr = 1; step("R7");
        msr_delta = 4'b0011; steps(2, "R7");
        rd_msr = 1; steps(2, "R7");
        msr_delta = 0;
        // R2 and R8: flow character gated by enhanced bit
        flow_det = 1; steps(2, "R2");
        efr_enh = 1; steps(2, "R8");
        rd_isr = 1; steps(2, "R8");
        // R9: pin changes with pair selection
        auto_cts_en = 1; cts_in = 1; steps(2, "R9");
        rd_msr = 1; step("R9");
        mcr_sel = 1; step("R9");
        dsr_in = 1; steps(2, "R9");
        rd_msr = 1; step("R9");
        auto_rts_en = 1; dtr_out = 1; steps(2, "R9");
        rd_msr = 1; step("R9");
        ien_we = 1; ien_wdata = 8'h7F; step("R2");
        dsr_in = 0; step("R2");
        dsr_in = 1; steps(2, "R2");
        efr_enh = 0; step("R2");
        // R10: several causes pending together
        efr_enh = 1; rd_msr = 1; step("R10");
        fifo_mode = 0; lsr_thre = 1; lsr_err = 4'b0001;
        msr_delta = 4'b0100; flow_det = 1; step("R10");
        rd_isr = 1; step("R10");
        rd_lsr = 1; step("R10");
        rd_isr = 1; step("R10");
        rd_isr = 1; step("R11");
        rd_msr = 1; step("R10");
        rd_isr = 1; steps(2, "R11");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule